// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block is the interrupt front end of a small processor core. It keeps two five-bit registers, one for source enables and one for pending flags, plus a three-state master enable (off, armed, on). Peripherals raise pending flags with single-cycle request pulses. The core reads both registers, writes them through a shared write-data bus, and arms or disarms the master enable.

At every instruction boundary that the core signals, the block makes one of two decisions. It either lets the next instruction proceed, shown by a one-cycle `exec_go` pulse, or it starts a service. A service raises `svc_req` with a vector address and a fixed machine-cycle cost. These stay up until the core acknowledges them, and the core then pushes the return address and jumps.

Arming the master enable takes effect one boundary late: the boundary that finds it armed only promotes it to on. When several sources are pending, a fixed priority picks one of them. Its flag alone is cleared and the master enable drops to off.

Top module: `intc_dispatch`

## Requirements
- R1: After reset, `ime_state` is 0 (off), both register read ports are zero, and `svc_req` and `exec_go` are low.
- R2: A write pulse on `en_wr` or `fl_wr` stores `reg_wdata[4:0]` into the enable or flag register at the next clock edge. Read bits 7 to 5 of both registers are always zero.
- R3: A pulse on `src_req[i]` sets flag bit i at the next edge. Bit 0 is vertical-blank, 1 display-status, 2 timer, 3 serial and 4 joypad. The request wins over a same-cycle register write and over a same-cycle service clear of that bit.
- R4: A boundary starts a service only when `ime_state` is 2 (on) and the enable AND flag registers are nonzero. In every other case that is not held by a pending service, `exec_go` pulses in the cycle after the boundary.
- R5: Among the serviceable bits, the lowest index wins. The vector is 0x40 + 8 × index, giving 0x40, 0x48, 0x50, 0x58 and 0x60.
- R6: When a service starts, `svc_req` rises in the cycle after the boundary, `ime_state` goes to off, and only the winning flag bit is cleared.
- R7: A boundary that finds `ime_state` = 1 (armed) moves it to on and pulses `exec_go`. No service is taken at that boundary, even with interrupts pending.
- R8: `ime_sched` moves off to armed and leaves on unchanged. `ime_clear` forces off and wins over `ime_sched` and over boundary promotion in the same cycle.
- R9: `svc_req` and `svc_vector` hold until `svc_ack`. `svc_req` drops at the edge after the acknowledge. Boundaries that arrive while `svc_req` is high cause no `exec_go` and no state change.
- R10: While `svc_req` is high, `svc_mcycles` reads 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 5 | Per-source request pulses |
| en_wr | input | 1 | Write strobe for the enable register |
| fl_wr | input | 1 | Write strobe for the flag register |
| reg_wdata | input | 8 | Write data for both registers |
| ien_rd | output | 8 | Enable register read value |
| ifl_rd | output | 8 | Flag register read value |
| ime_sched | input | 1 | Arm the master enable |
| ime_clear | input | 1 | Disarm the master enable |
| ime_state | output | 2 | Master enable: 0 off, 1 armed, 2 on |
| boundary | input | 1 | Instruction boundary strobe from the core |
| exec_go | output | 1 | Next instruction may run |
| svc_req | output | 1 | Service request to the core |
| svc_vector | output | 16 | Service vector address |
| svc_mcycles | output | 4 | Machine-cycle cost of the service |
| svc_ack | input | 1 | Core acknowledge of the service request |

## Verification
Every result is registered once. A boundary's outcome (`exec_go` or the rise of `svc_req`), register writes, request pulses and master-enable commands all become visible in the cycle after the edge that sampled them. `svc_req` falls one edge after `svc_ack`. The driver pushes each boundary's expected outcome into a queue before the sampling edge, and a monitor compares it at the following falling edge. The driver also checks register and master-enable values one nanosecond after the edge, so no sample coincides with an active edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC     = 5;
    localparam int REG_W    = 8;
    localparam int VEC_W    = 16;
    localparam int MC_W     = 4;
    localparam int SVC_MC   = 5;
    localparam int VEC_BASE = 'h40;
    localparam int VEC_STEP = 8;

    typedef enum logic [1:0] {
        IME_OFF   = 2'd0,
        IME_SCHED = 2'd1,
        IME_ON    = 2'd2
    } ime_e;

endpackage

// File: rtl/intc_srcreg.sv
module intc_srcreg #(
    parameter int N = 5,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q,
    output logic [W-1:0] rd
);

    typedef struct packed {
        logic [N-1:0] bits;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.bits = wdata[N-1:0];
        end
        st_d.bits = st_d.bits & ~clr;
        st_d.bits = st_d.bits | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q  = st_q.bits;
    assign rd = {{(W-N){1'b0}}, st_q.bits};

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N     = 5,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     pend,
    output logic             any,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx
);

    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_top
            assign grant[i] = pend[i];
        end else begin : g_rest
            assign grant[i] = pend[i] & ~(|pend[i-1:0]);
        end
    end

    assign any = |pend;

    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) begin
                idx = idx | IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/intc_master.sv
module intc_master
    import intc_pkg::*;
#(
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          ime_sched,
    input  logic          ime_clear,
    input  logic          svc_ack,
    input  logic          pend_any,
    input  logic [VW-1:0] vec_in,
    output logic          take,
    output logic          svc_req,
    output logic [VW-1:0] svc_vec,
    output logic          exec_go,
    output ime_e          ime
);

    typedef struct packed {
        ime_e          ime;
        logic          svc;
        logic [VW-1:0] vec;
        logic          go;
    } mst_t;

    mst_t st_d, st_q;

    logic live_bnd;

    assign live_bnd = boundary && !st_q.svc;
    assign take     = live_bnd && (st_q.ime == IME_ON) && pend_any;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (st_q.svc && svc_ack) begin
            st_d.svc = 1'b0;
        end
        if (live_bnd) begin
            if (st_q.ime == IME_SCHED) begin
                st_d.ime = IME_ON;
                st_d.go  = 1'b1;
            end else if (take) begin
                st_d.ime = IME_OFF;
                st_d.svc = 1'b1;
                st_d.vec = vec_in;
            end else begin
                st_d.go = 1'b1;
            end
        end
        if (ime_sched && st_d.ime == IME_OFF) begin
            st_d.ime = IME_SCHED;
        end
        if (ime_clear) begin
            st_d.ime = IME_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ime: IME_OFF, svc: 1'b0, vec: '0, go: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign svc_req = st_q.svc;
    assign svc_vec = st_q.vec;
    assign exec_go = st_q.go;
    assign ime     = st_q.ime;

endmodule

// File: rtl/intc_dispatch.sv
module intc_dispatch
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic             en_wr,
    input  logic             fl_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] ien_rd,
    output logic [REG_W-1:0] ifl_rd,
    input  logic             ime_sched,
    input  logic             ime_clear,
    output logic [1:0]       ime_state,
    input  logic             boundary,
    output logic             exec_go,
    output logic             svc_req,
    output logic [VEC_W-1:0] svc_vector,
    output logic [MC_W-1:0]  svc_mcycles,
    input  logic             svc_ack
);

    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]  en_q, fl_q, pend, grant, clr_mask;
    logic             pend_any, take;
    logic [IDX_W-1:0] win_idx;
    logic [VEC_W-1:0] vec_sel;
    ime_e             ime;

    intc_srcreg #(.N(NSRC), .W(REG_W)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (reg_wdata),
        .set   ('0),
        .clr   ('0),
        .q     (en_q),
        .rd    (ien_rd)
    );

    intc_srcreg #(.N(NSRC), .W(REG_W)) u_fl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fl_wr),
        .wdata (reg_wdata),
        .set   (src_req),
        .clr   (clr_mask),
        .q     (fl_q),
        .rd    (ifl_rd)
    );

    assign pend = en_q & fl_q;

    intc_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
        .pend  (pend),
        .any   (pend_any),
        .grant (grant),
        .idx   (win_idx)
    );

    assign vec_sel  = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);
    assign clr_mask = take ? grant : '0;

    intc_master #(.VW(VEC_W)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .ime_sched (ime_sched),
        .ime_clear (ime_clear),
        .svc_ack   (svc_ack),
        .pend_any  (pend_any),
        .vec_in    (vec_sel),
        .take      (take),
        .svc_req   (svc_req),
        .svc_vec   (svc_vector),
        .exec_go   (exec_go),
        .ime       (ime)
    );

    assign ime_state   = ime;
    assign svc_mcycles = svc_req ? MC_W'(SVC_MC) : '0;

endmodule

// File: rtl/intc_dispatch_chk.sv
module intc_dispatch_chk
    import intc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_req,
    input logic             ime_clear,
    input logic             boundary,
    input logic             svc_ack,
    input logic [REG_W-1:0] ien_rd,
    input logic [REG_W-1:0] ifl_rd,
    input logic [1:0]       ime_state,
    input logic             exec_go,
    input logic             svc_req,
    input logic [VEC_W-1:0] svc_vector,
    input logic [MC_W-1:0]  svc_mcycles
);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_rd[REG_W-1:NSRC] == '0 && ifl_rd[REG_W-1:NSRC] == '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // R3
        src_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> ifl_rd[i]);
    end

    // R4
    go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |-> !svc_req);

    // R5
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (svc_vector[2:0] == 3'd0 && svc_vector >= VEC_W'(VEC_BASE)
                     && svc_vector <= VEC_W'(VEC_BASE + (NSRC-1)*VEC_STEP)));

    // R6
    svc_ime_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_req) |-> ime_state != 2'd2);

    // R7
    sched_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && !svc_req && ime_state == 2'd1 && !ime_clear
        |=> ime_state == 2'd2 && exec_go && !svc_req);

    // R9
    svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req && !svc_ack |=> svc_req && $stable(svc_vector));

    // R9
    svc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req && svc_ack |=> !svc_req);

    // R10
    svc_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> svc_mcycles == MC_W'(SVC_MC));

endmodule

bind intc_dispatch intc_dispatch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req     (src_req),
    .ime_clear   (ime_clear),
    .boundary    (boundary),
    .svc_ack     (svc_ack),
    .ien_rd      (ien_rd),
    .ifl_rd      (ifl_rd),
    .ime_state   (ime_state),
    .exec_go     (exec_go),
    .svc_req     (svc_req),
    .svc_vector  (svc_vector),
    .svc_mcycles (svc_mcycles)
);

// File: tb/intc_dispatch_tb.sv
`timescale 1ns/1ps
module intc_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_req = '0;
    logic        en_wr = 1'b0, fl_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  ien_rd, ifl_rd;
    logic        ime_sched = 1'b0, ime_clear = 1'b0;
    logic [1:0]  ime_state;
    logic        boundary = 1'b0;
    logic        exec_go, svc_req;
    logic [15:0] svc_vector;
    logic [3:0]  svc_mcycles;
    logic        svc_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_svc;
        logic [15:0] vec;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    intc_dispatch u_dut (
        .clk (clk), .rst_n (rst_n), .src_req (src_req),
        .en_wr (en_wr), .fl_wr (fl_wr), .reg_wdata (reg_wdata),
        .ien_rd (ien_rd), .ifl_rd (ifl_rd),
        .ime_sched (ime_sched), .ime_clear (ime_clear), .ime_state (ime_state),
        .boundary (boundary), .exec_go (exec_go), .svc_req (svc_req),
        .svc_vector (svc_vector), .svc_mcycles (svc_mcycles), .svc_ack (svc_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bnd(input bit is_svc, input logic [15:0] vec, input string tag);
        exp_q.push_back('{is_svc: is_svc, vec: vec, tag: tag});
        boundary = 1'b1;
        tick();
        boundary = 1'b0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_wr = 1'b1; reg_wdata = v; tick(); en_wr = 1'b0;
    endtask

    task automatic wr_fl(input logic [7:0] v);
        fl_wr = 1'b1; reg_wdata = v; tick(); fl_wr = 1'b0;
    endtask

    task automatic pulse_sched();
        ime_sched = 1'b1; tick(); ime_sched = 1'b0;
    endtask

    task automatic ack();
        svc_ack = 1'b1; tick(); svc_ack = 1'b0;
    endtask

    // Monitor: compares each boundary outcome against the scoreboard queue.
    logic prev_svc = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exec_go || (svc_req && !prev_svc)) begin
                if (exp_q.size() == 0) begin
                    chk("R9 unexpected boundary outcome", {exec_go, svc_req}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " outcome"}, {30'd0, svc_req && !prev_svc, exec_go},
                        e.is_svc ? 32'h2 : 32'h1);
                    if (e.is_svc) begin
                        chk({e.tag, " vector"}, svc_vector, e.vec);
                    end
                end
            end
            prev_svc = svc_req;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 ime", ime_state, 0);
        chk("R1 enable", ien_rd, 0);
        chk("R1 flags", ifl_rd, 0);
        chk("R1 svc_req", svc_req, 0);
        chk("R1 exec_go", exec_go, 0);

        wr_en(8'hFF);
        chk("R2 enable masked", ien_rd, 8'h1F);
        wr_fl(8'hE0);
        chk("R2 flag upper bits", ifl_rd, 8'h00);

        bnd(0, 0, "R4 idle");
        src_req = 5'b10100; tick(); src_req = '0;
        chk("R3 request set", ifl_rd, 8'h14);
        bnd(0, 0, "R4 ime off pending");
        chk("R4 no service", svc_req, 0);

        pulse_sched();
        chk("R8 armed", ime_state, 1);
        bnd(0, 0, "R7 promote");
        chk("R7 on", ime_state, 2);
        chk("R7 no service", svc_req, 0);

        bnd(1, 16'h50, "R5 timer");
        chk("R6 svc_req", svc_req, 1);
        chk("R6 ime off", ime_state, 0);
        chk("R6 only winner cleared", ifl_rd, 8'h10);
        chk("R10 cost", svc_mcycles, 5);

        boundary = 1'b1; tick(); boundary = 1'b0;
        chk("R9 ignored boundary ime", ime_state, 0);
        chk("R9 ignored boundary flags", ifl_rd, 8'h10);
        tick(); tick();
        chk("R9 held req", svc_req, 1);
        chk("R9 held vector", svc_vector, 16'h50);
        ack();
        chk("R9 released", svc_req, 0);

        wr_fl(8'h1F);
        for (int k = 0; k < 5; k++) begin
            pulse_sched();
            bnd(0, 0, "R7 rearm");
            bnd(1, 16'(16'h40 + 8 * k), "R5 priority");
            chk("R6 priority clear", ifl_rd, 32'h1F & ~((32'd1 << (k + 1)) - 1));
            ack();
        end

        wr_en(8'h01);
        wr_fl(8'h02);
        pulse_sched();
        bnd(0, 0, "R7 rearm");
        bnd(0, 0, "R4 masked by enable");
        chk("R4 ime stays on", ime_state, 2);

        wr_fl(8'h01);
        exp_q.push_back('{is_svc: 1'b1, vec: 16'h40, tag: "R3 race"});
        boundary = 1'b1; src_req = 5'b00001;
        tick();
        boundary = 1'b0; src_req = '0;
        chk("R3 request beats clear", ifl_rd, 8'h01);
        chk("R3 service taken", svc_req, 1);
        ack();

        ime_sched = 1'b1; ime_clear = 1'b1; tick();
        ime_sched = 1'b0; ime_clear = 1'b0;
        chk("R8 clear beats sched", ime_state, 0);
        pulse_sched();
        wr_en(8'h00);
        bnd(0, 0, "R7 rearm");
        pulse_sched();
        chk("R8 sched keeps on", ime_state, 2);
        ime_clear = 1'b1; tick(); ime_clear = 1'b0;
        chk("R8 clear", ime_state, 0);
        pulse_sched();
        exp_q.push_back('{is_svc: 1'b0, vec: 16'h0, tag: "R8 clear vs promote"});
        boundary = 1'b1; ime_clear = 1'b1; tick();
        boundary = 1'b0; ime_clear = 1'b0;
        chk("R8 clear beats promotion", ime_state, 0);

        tick(); tick();
        chk("R4 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule